// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year offset. A prescaler divides the reference clock, nominally 32768 Hz, down to a one-cycle seconds pulse. Each pulse advances the time by one second, with carries that cascade through every field. Hours always run in 24-hour form. Day rollover follows the month length, and February gets a 29th day when a leap flag is set.

Software reaches the block through a word-wide register port. Writes to the seven time words do not touch the running time. They fill a set of staging registers. A write to the trigger word with its commit bit set copies every staged field into the running counter in the same cycle, and the prescaler restarts from zero. Reads always return the running counter. Software computes the leap status itself and writes it as the top bit of the year word.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the running time is 00:00:00, weekday 0, day 01, month 01, year 00, leap flag 0. The seconds pulse is low.
- R2: Writes to words 0 to 6 (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year) go only to staging registers. Reads of those words return the running time, which a field write does not alter.
- R3: A write of word 7 with bit 15 set loads all seven staged fields into the running time together. A write of word 7 with bit 15 clear has no effect. Word 7 reads as 0x0000.
- R4: `sec_tick` is high for one cycle in every 2^PRESC_W cycles. After a commit, the first advance happens exactly 2^PRESC_W clock edges after the commit edge.
- R5: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the day. Each digit counts in BCD, so 09 is followed by 10.
- R6: The weekday advances together with the day and wraps from 6 to 0.
- R7: Day wraps to 01 after 30 in months 04, 06, 09 and 11. It wraps after 31 in months 01, 03, 05, 07, 08, 10 and 12, and in those months it counts 30 up to 31.
- R8: In month 02 the day wraps after 28 when the leap flag (bit 15 of the year word) is 0, and after 29 when it is 1. The flag reads back in bit 15 of word 6.
- R9: Month wraps from 12 to 01 and carries into the year. The year counts in BCD (09 to 10) and wraps from 99 to 00.
- R10: Field bits above each width are dropped. Seconds and minutes keep 7 bits, hours and day 6, weekday 3, month 5 and year 8 (plus the leap flag). Dropped bits read as 0.
- R11: Word 8 is the mode control word and reads 0x0001 (bit 0: 24-hour mode). Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| sec_tick | output | 1 | One-cycle seconds pulse |

## Verification
The hardest states to reach from the ports are the rare carries: the end of February in both leap states, the ends of 30- and 31-day months, and the turn of the century. Counting up to them from reset would take years of simulated seconds. The stimulus therefore commits a time one second before each boundary through the staging registers and the trigger. It then waits exactly one prescaler period, with the prescaler shortened by parameter. Cascades that wrap every field at once, such as the turn of the century, are checked in a single step.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int TRIG_BIT = 15;
    localparam int LEAP_BIT = 15;

    localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 4'd2;
    localparam logic [ADDR_W-1:0] A_WDAY = 4'd3;
    localparam logic [ADDR_W-1:0] A_DAY  = 4'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 4'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 4'd6;
    localparam logic [ADDR_W-1:0] A_TRIG = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd8;

    localparam logic [WORD_W-1:0] CTRL_VALUE = 16'h0001;

    typedef struct packed {
        logic       leap;
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] day;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_time_t;

    function automatic cal_time_t cal_reset_time();
        cal_time_t t;
        t      = '0;
        t.day  = 6'h01;
        t.mon  = 5'h01;
        return t;
    endfunction

    // Two-digit BCD increment; the caller handles the wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = v[7:4] + 4'd1;
        end else begin
            r[3:0] = v[3:0] + 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction

    // Last day of a month in BCD.
    function automatic logic [5:0] month_last_day(input logic [4:0] mon, input logic leap);
        logic [5:0] d;
        case (mon)
            5'h02:                      d = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
            default:                    d = 6'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESC_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};

    logic [PRESC_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || restart) count <= '0;
        else                count <= count + 1'b1;
    end

    assign tick = (count == LAST);
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t cur
);
    logic       sec_end, min_end, hour_end, day_end, mon_end, year_end;
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] sec_inc, min_inc, hour_inc, day_inc, mon_inc, year_inc;
    cal_time_t  nxt;

    always_comb begin
        sec_end  = cur.sec  >= 7'h59;
        min_end  = cur.min  >= 7'h59;
        hour_end = cur.hour >= 6'h23;
        day_end  = cur.day  >= month_last_day(cur.mon, cur.leap);
        mon_end  = cur.mon  >= 5'h12;
        year_end = cur.year >= 8'h99;

        c_min  = tick  & sec_end;
        c_hour = c_min & min_end;
        c_day  = c_hour & hour_end;
        c_mon  = c_day & day_end;
        c_year = c_mon & mon_end;

        sec_inc  = bcd_inc({1'b0, cur.sec});
        min_inc  = bcd_inc({1'b0, cur.min});
        hour_inc = bcd_inc({2'b0, cur.hour});
        day_inc  = bcd_inc({2'b0, cur.day});
        mon_inc  = bcd_inc({3'b0, cur.mon});
        year_inc = bcd_inc(cur.year);

        nxt = cur;
        if (tick)   nxt.sec  = sec_end  ? 7'h00 : sec_inc[6:0];
        if (c_min)  nxt.min  = min_end  ? 7'h00 : min_inc[6:0];
        if (c_hour) nxt.hour = hour_end ? 6'h00 : hour_inc[5:0];
        if (c_day) begin
            nxt.day  = day_end ? 6'h01 : day_inc[5:0];
            nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
        end
        if (c_mon)  nxt.mon  = mon_end  ? 5'h01 : mon_inc[4:0];
        if (c_year) nxt.year = year_end ? 8'h00 : year_inc;
    end

    always_ff @(posedge clk) begin
        if (rst)       cur <= cal_reset_time();
        else if (load) cur <= load_val;
        else           cur <= nxt;
    end
endmodule

// File: rtl/cal_regs.sv
module cal_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  cal_time_t         live,
    output cal_time_t         shadow,
    output logic              commit,
    output logic [WORD_W-1:0] rdata
);
    logic wdata_unused;
    assign wdata_unused = ^wdata[14:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= cal_reset_time();
        end else if (we) begin
            case (addr)
                A_SEC:  shadow.sec  <= wdata[6:0];
                A_MIN:  shadow.min  <= wdata[6:0];
                A_HOUR: shadow.hour <= wdata[5:0];
                A_WDAY: shadow.wday <= wdata[2:0];
                A_DAY:  shadow.day  <= wdata[5:0];
                A_MON:  shadow.mon  <= wdata[4:0];
                A_YEAR: begin
                    shadow.year <= wdata[7:0];
                    shadow.leap <= wdata[LEAP_BIT];
                end
                default: ;
            endcase
        end
    end

    assign commit = we && (addr == A_TRIG) && wdata[TRIG_BIT];

    always_comb begin
        rdata = '0;
        case (addr)
            A_SEC:  rdata[6:0] = live.sec;
            A_MIN:  rdata[6:0] = live.min;
            A_HOUR: rdata[5:0] = live.hour;
            A_WDAY: rdata[2:0] = live.wday;
            A_DAY:  rdata[5:0] = live.day;
            A_MON:  rdata[4:0] = live.mon;
            A_YEAR: begin
                rdata[7:0]      = live.year;
                rdata[LEAP_BIT] = live.leap;
            end
            A_CTRL: rdata = CTRL_VALUE;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int PRESC_W = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sec_tick
);
    cal_time_t live_time;
    cal_time_t shadow_time;
    logic      commit;

    cal_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .live   (live_time),
        .shadow (shadow_time),
        .commit (commit),
        .rdata  (reg_rdata)
    );

    cal_prescaler #(.PRESC_W(PRESC_W)) i_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (commit),
        .tick    (sec_tick)
    );

    cal_counter i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (commit),
        .load_val (shadow_time),
        .cur      (live_time)
    );
endmodule

// File: rtl/cal_checker.sv
module cal_checker
    import cal_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick,
    input logic      commit,
    input cal_time_t live,
    input cal_time_t shadow
);
    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (rst)
        commit |=> live == $past(shadow)); // R3

    AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!commit && !tick) |=> $stable(live)); // R2

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R4

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
        commit |=> !tick); // R4

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !commit && live.sec == 7'h59) |=> live.sec == 7'h00); // R5

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !commit && live.sec == 7'h59 && live.min == 7'h59 &&
         live.hour == 6'h23 && live.wday == 3'd6) |=> live.wday == 3'd0); // R6
endmodule

bind bcd_calendar_clock cal_checker i_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (sec_tick),
    .commit (commit),
    .live   (live_time),
    .shadow (shadow_time)
);

// File: tb/test_bcd_calendar_clock.sv
module test_bcd_calendar_clock;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW  = 3;
    localparam int PER = 1 << PW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sec_tick;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bcd_calendar_clock #(.PRESC_W(PW)) i_bcd_calendar_clock (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // ends at the falling edge right after the commit edge
    task automatic set_time(input logic [15:0] s, input logic [15:0] m, input logic [15:0] h,
                            input logic [15:0] w, input logic [15:0] d, input logic [15:0] mo,
                            input logic [15:0] y);
        wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, w);
        wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y);
        wr(4'd7, 16'h8000);
    endtask

    task automatic step(input int n);
        repeat (n * PER) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd_check("R1 sec", 4'd0, 16'h0000);
        rd_check("R1 min", 4'd1, 16'h0000);
        rd_check("R1 hour", 4'd2, 16'h0000);
        rd_check("R1 wday", 4'd3, 16'h0000);
        rd_check("R1 day", 4'd4, 16'h0001);
        rd_check("R1 mon", 4'd5, 16'h0001);
        rd_check("R1 year", 4'd6, 16'h0000);
        check("R1 tick low", {15'b0, sec_tick}, 16'h0000);
        rd_check("R11 ctrl", 4'd8, 16'h0001);
    endtask

    task automatic t_staging;
        set_time(16'h10, 16'h20, 16'h05, 16'h2, 16'h11, 16'h03, 16'h42);
        rd_check("R3 commit year", 4'd6, 16'h0042);
        rd_check("R3 commit mon", 4'd5, 16'h0003);
        wr(4'd6, 16'h0055);
        wr(4'd5, 16'h0007);
        rd_check("R2 year unchanged", 4'd6, 16'h0042);
        rd_check("R2 mon unchanged", 4'd5, 16'h0003);
        wr(4'd7, 16'h7FFF);
        rd_check("R3 no-bit trigger", 4'd6, 16'h0042);
        rd_check("R3 trig reads 0", 4'd7, 16'h0000);
        wr(4'd7, 16'h8000);
        rd_check("R3 staged year", 4'd6, 16'h0055);
        rd_check("R3 staged mon", 4'd5, 16'h0007);
    endtask

    task automatic t_tick_timing;
        int seen;
        set_time(16'h00, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h00);
        seen = -1;
        for (int i = 0; i < PER; i++) begin
            if (sec_tick && seen < 0) seen = i;
            if (i < PER - 1) @(negedge clk);
        end
        check("R4 tick position", seen[15:0], 16'(PER - 1));
        @(negedge clk);
        rd_check("R4 first advance", 4'd0, 16'h0001);
        step(1);
        rd_check("R4 second advance", 4'd0, 16'h0002);
    endtask

    task automatic t_cascade;
        set_time(16'h09, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h00);
        step(1);
        rd_check("R5 bcd 09->10", 4'd0, 16'h0010);
        set_time(16'h59, 16'h59, 16'h23, 16'h6, 16'h15, 16'h05, 16'h30);
        step(1);
        rd_check("R5 sec wrap", 4'd0, 16'h0000);
        rd_check("R5 min wrap", 4'd1, 16'h0000);
        rd_check("R5 hour wrap", 4'd2, 16'h0000);
        rd_check("R5 day carry", 4'd4, 16'h0016);
        rd_check("R6 wday wrap", 4'd3, 16'h0000);
        set_time(16'h59, 16'h59, 16'h23, 16'h2, 16'h15, 16'h05, 16'h30);
        step(1);
        rd_check("R6 wday inc", 4'd3, 16'h0003);
    endtask

    task automatic t_months;
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h30, 16'h04, 16'h30);
        step(1);
        rd_check("R7 30-day wrap day", 4'd4, 16'h0001);
        rd_check("R7 30-day wrap mon", 4'd5, 16'h0005);
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h30, 16'h01, 16'h30);
        step(1);
        rd_check("R7 jan 30->31", 4'd4, 16'h0031);
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h31, 16'h10, 16'h30);
        step(1);
        rd_check("R7 31-day wrap day", 4'd4, 16'h0001);
        rd_check("R7 31-day wrap mon", 4'd5, 16'h0011);
    endtask

    task automatic t_february;
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h28, 16'h02, 16'h8024);
        step(1);
        rd_check("R8 leap 28->29", 4'd4, 16'h0029);
        rd_check("R8 leap flag read", 4'd6, 16'h8024);
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h29, 16'h02, 16'h8024);
        step(1);
        rd_check("R8 leap 29->01", 4'd4, 16'h0001);
        rd_check("R8 leap mon", 4'd5, 16'h0003);
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h28, 16'h02, 16'h0023);
        step(1);
        rd_check("R8 common 28->01", 4'd4, 16'h0001);
        rd_check("R8 common mon", 4'd5, 16'h0003);
    endtask

    task automatic t_year;
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h31, 16'h12, 16'h0099);
        step(1);
        rd_check("R9 year wrap", 4'd6, 16'h0000);
        rd_check("R9 month wrap", 4'd5, 16'h0001);
        rd_check("R9 day wrap", 4'd4, 16'h0001);
        set_time(16'h59, 16'h59, 16'h23, 16'h0, 16'h31, 16'h12, 16'h0009);
        step(1);
        rd_check("R9 year 09->10", 4'd6, 16'h0010);
    endtask

    task automatic t_widths;
        set_time(16'hFF00, 16'hFF23, 16'hFFD5, 16'hFFF4, 16'hFFC7, 16'hFFE9, 16'h7F45);
        rd_check("R10 min mask", 4'd1, 16'h0023);
        rd_check("R10 hour mask", 4'd2, 16'h0015);
        rd_check("R10 wday mask", 4'd3, 16'h0004);
        rd_check("R10 day mask", 4'd4, 16'h0007);
        rd_check("R10 mon mask", 4'd5, 16'h0009);
        rd_check("R10 year mask", 4'd6, 16'h0045);
    endtask

    task automatic t_ctrl;
        wr(4'd8, 16'h0000);
        rd_check("R11 ctrl after write", 4'd8, 16'h0001);
        rd_check("R11 year untouched", 4'd6, 16'h0045);
        wr(4'd8, 16'hFFFF);
        rd_check("R11 ctrl after ones", 4'd8, 16'h0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_staging();
        t_tick_timing();
        t_cascade();
        t_months();
        t_february();
        t_year();
        t_widths();
        t_ctrl();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule